// File: doc/BRIEF.md
# Energy Counter Integrator and Pulser

This block follows a free-running energy up/down counter that wraps, and turns its successive readings into a long-term signed energy total. It also produces a pulse for every unit of energy.

Each time a new counter reading arrives, the block does three things:
- It takes the wrap-aware signed difference from the previous reading.
- It remembers the new reading as the previous one.
- It records the sign of the difference as the flow direction.

The difference is not added all at once. It is released into a fractional accumulator over a fixed number of sub-tick strobes. Each sub-tick adds one share, and the last sub-tick adds whatever is left, so no energy is dropped by the division. Releasing the energy in small shares places each output pulse more precisely in time.

Whenever the fractional accumulator reaches plus or minus a programmable threshold, three things happen on the next clock:
- The integer total moves by one in that direction.
- The threshold is taken out of the fractional part.
- A one-clock pulse is produced.

A host reads the counter about 32 times per second and strobes sub-ticks 16 times per reading. It sets the threshold to the number of counter units per output step, for example 0xA0021 counts for one step per 10 Wh.

Top module: `energy_integrator`

## Requirements
- R1: After reset, total is 0, dir is 0 and pulse is 0. The first reading after reset is only stored as the previous value and adds no energy.
- R2: A later reading gives the difference (new − previous) modulo 2^CNT_W, sign-extended from bit CNT_W−1, so a forward step across the counter wrap counts as a small positive amount.
- R3: On every reading except the first after reset, dir takes the sign of the difference: 1 for reverse (negative), 0 for forward or zero. Without a reading, dir holds its value.
- R4: A reading loads a pending amount and a share equal to the pending amount arithmetically shifted right by SPREAD_LOG2 bits. Each of the next 2^SPREAD_LOG2 − 1 sub-ticks adds the share to the fractional part. The final sub-tick adds whatever is still pending.
- R5: A sub-tick when no spread is in progress, or in the same cycle as a reading, adds nothing.
- R6: A reading that arrives before the spread ends carries the un-added pending amount into the new spread, so no energy is lost.
- R7: When thr is nonzero and the fractional part is at least thr, the next clock raises total by 1 and subtracts thr from the fractional part.
- R8: When thr is nonzero and the fractional part is at most −thr, the next clock lowers total by 1 and adds thr to the fractional part.
- R9: A threshold of 0 disables stepping: total does not change.
- R10: pulse is high for exactly the clock cycles in which total has just changed. There is at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | New counter reading present this cycle |
| rd_val | input | CNT_W | Counter reading |
| tick | input | 1 | Sub-tick strobe |
| thr | input | ACC_W | Step threshold in counter units (positive) |
| total | output | ACC_W | Signed integer energy total |
| dir | output | 1 | Direction of the last difference, 1 = reverse |
| pulse | output | 1 | One-clock pulse per integer step |

## Verification
The bench builds the block with its default parameters: a 20-bit counter, 32-bit accumulators and 16 sub-ticks per reading. It uses very small thresholds such as 17, 20 and 100 counts, so each step, the remainder on the last sub-tick, and downward steps all appear within a few dozen clocks. The first reading is placed 16 counts below the wrap point, so the next forward reading crosses the 2^20 boundary. A reading issued in the middle of a spread, and a threshold whose value would only be reached if carried energy were kept, together expose any lost remainder.

// File: rtl/energy_integrator.sv
module energy_integrator #(
  parameter int CNT_W       = 20,
  parameter int ACC_W       = 32,
  parameter int SPREAD_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_vld,
  input  logic [CNT_W-1:0]        rd_val,
  input  logic                    tick,
  input  logic [ACC_W-1:0]        thr,
  output logic signed [ACC_W-1:0] total,
  output logic                    dir,
  output logic                    pulse
);
  localparam int SPREAD = 1 << SPREAD_LOG2;
  localparam int CW     = SPREAD_LOG2 + 1;

  logic [CNT_W-1:0]        prev;
  logic                    primed;
  logic signed [ACC_W-1:0] pend, share, frac;
  logic [CW-1:0]           left;

  wire [CNT_W-1:0]        raw_d   = rd_val - prev;
  wire signed [ACC_W-1:0] diff    = {{(ACC_W-CNT_W){raw_d[CNT_W-1]}}, raw_d};
  wire signed [ACC_W-1:0] pend_in = pend + diff;
  wire                    take    = tick && !rd_vld && (left != '0);
  wire                    last    = (left == CW'(1));
  wire signed [ACC_W-1:0] add     = take ? (last ? pend : share) : '0;
  wire signed [ACC_W-1:0] thr_s   = $signed(thr);
  wire                    thr_on  = (thr != '0);
  wire                    step_up = thr_on && (frac >= thr_s);
  wire                    step_dn = thr_on && !step_up && (frac <= -thr_s);
  wire signed [ACC_W-1:0] corr    = step_up ? thr_s : (step_dn ? -thr_s : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      primed <= 1'b0;
      dir    <= 1'b0;
      pend   <= '0;
      share  <= '0;
      left   <= '0;
      frac   <= '0;
      total  <= '0;
      pulse  <= 1'b0;
    end else begin
      if (rd_vld) begin
        prev   <= rd_val;
        primed <= 1'b1;
        if (primed) begin
          dir   <= raw_d[CNT_W-1];
          pend  <= pend_in;
          share <= pend_in >>> SPREAD_LOG2;
          left  <= CW'(SPREAD);
        end
      end else if (take) begin
        pend <= pend - add;
        left <= left - CW'(1);
      end
      frac  <= frac + add - corr;
      total <= total + (step_up ? ACC_W'(1) : (step_dn ? {ACC_W{1'b1}} : '0));
      pulse <= step_up || step_dn;
    end
  end
endmodule

// File: rtl/energy_integrator_chk.sv
module energy_integrator_chk #(
  parameter int ACC_W = 32,
  parameter int CW    = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_vld,
  input logic                    tick,
  input logic [ACC_W-1:0]        thr,
  input logic signed [ACC_W-1:0] total,
  input logic                    dir,
  input logic                    pulse,
  input logic signed [ACC_W-1:0] frac,
  input logic signed [ACC_W-1:0] pend,
  input logic [CW-1:0]           left
);
  // R10
  pulse_tracks_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse == (total != $past(total)));

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0 && frac >= $signed(thr)) |=> (total == $past(total) + 1));

  // R8
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0 && frac <= -$signed(thr)) |=> (total == $past(total) - 1));

  // R9
  zero_thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> $stable(total));

  // R5
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !rd_vld) |=> $stable(pend));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |=> $stable(dir));
endmodule

bind energy_integrator energy_integrator_chk #(.ACC_W(ACC_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .tick(tick), .thr(thr),
  .total(total), .dir(dir), .pulse(pulse), .frac(frac), .pend(pend), .left(left)
);

// File: tb/energy_integrator_test.sv
module energy_integrator_test;
  localparam int CNT_W = 20;
  localparam int ACC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_vld = 1'b0;
  logic [CNT_W-1:0] rd_val = '0;
  logic tick = 1'b0;
  logic [ACC_W-1:0] thr = '0;
  logic signed [ACC_W-1:0] total;
  logic dir, pulse;

  int checks = 0;
  int errors = 0;
  int pcount = 0;
  bit done = 1'b0;
  logic [CNT_W-1:0] last_rd = '0;

  always #2 clk = ~clk;

  energy_integrator uut (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_val(rd_val), .tick(tick),
    .thr(thr), .total(total), .dir(dir), .pulse(pulse)
  );

  always @(negedge clk) if (pulse) pcount++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_abs(input logic [CNT_W-1:0] v);
    @(negedge clk);
    rd_val = v; rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
    last_rd = v;
  endtask

  task automatic read_rel(input int d);
    read_abs(last_rd + CNT_W'(d));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      idle(3);
    end
  endtask

  task automatic t_reset;
    chk("R1 total after reset", total, 0);
    chk("R1 dir after reset", dir, 0);
    chk("R1 pulse after reset", pulse, 0);
  endtask

  task automatic t_prime;
    thr = 1;
    read_abs(20'hFFFF0);
    ticks(16);
    idle(4);
    chk("R1 first reading adds nothing", total, 0);
    chk("R1 first reading no pulse", pcount, 0);
  endtask

  task automatic t_forward_wrap;
    int t0 = total, p0 = pcount;
    thr = 100;
    read_rel(1600);
    chk("R3 forward dir", dir, 0);
    ticks(16);
    idle(4);
    chk("R2 R7 wrap forward total", total - t0, 16);
    chk("R10 forward pulse count", pcount - p0, 16);
  endtask

  task automatic t_remainder;
    int t0 = total;
    thr = 1615;
    read_rel(1615);
    ticks(15);
    idle(4);
    chk("R4 fifteen shares below threshold", total - t0, 0);
    ticks(1);
    idle(4);
    chk("R4 last tick adds remainder", total - t0, 1);
  endtask

  task automatic t_reverse;
    int t0 = total, p0 = pcount;
    thr = 20;
    read_rel(-320);
    chk("R3 reverse dir", dir, 1);
    ticks(16);
    idle(4);
    chk("R8 reverse total", total - t0, -16);
    chk("R10 reverse pulse count", pcount - p0, 16);
  endtask

  task automatic t_neg_remainder;
    int t0 = total, p0 = pcount;
    thr = 17;
    read_rel(-17);
    ticks(9);
    idle(4);
    chk("R8 down step after nine ticks", total - t0, -1);
    ticks(7);
    idle(4);
    chk("R4 negative remainder balances", total - t0, -1);
    chk("R10 one pulse", pcount - p0, 1);
  endtask

  task automatic t_zero_thr;
    int t0 = total, p0 = pcount;
    thr = 0;
    read_rel(1600);
    chk("R3 dir back to forward", dir, 0);
    ticks(16);
    idle(4);
    chk("R9 zero threshold no step", total - t0, 0);
    chk("R9 zero threshold no pulse", pcount - p0, 0);
    thr = 1600;
    idle(4);
    chk("R7 step once threshold set", total - t0, 1);
  endtask

  task automatic t_interrupt;
    int t0 = total;
    thr = 160;
    read_rel(160);
    ticks(4);
    read_rel(96);
    ticks(16);
    idle(4);
    chk("R6 carried energy reaches threshold", total - t0, 1);
    ticks(5);
    idle(4);
    chk("R5 idle ticks no step", total - t0, 1);
    read_rel(64);
    ticks(16);
    idle(4);
    chk("R5 R6 residue exactly 96", total - t0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prime();
    t_forward_wrap();
    t_remainder();
    t_reverse();
    t_neg_remainder();
    t_zero_thr();
    t_interrupt();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule